// File: doc/BRIEF.md
# DQS Gate Training Sequencer

This block runs one DQS squelch (gate) calibration on a DRAM data path with two byte lanes and protects the refresh schedule around it. When a start request is accepted, it saves the current refresh-interval setting and writes zero to the interval register. This halts automatic refresh while the PHY calibrates. It then writes the calibration-start setting to the PHY control field and waits until the PHY status reports completion on both byte lanes at once.

Once calibration ends, the block writes the no-calibration setting back to the PHY control field, keeping normal mode. It then issues a fixed number of back-to-back refresh commands through a request/acknowledge port. These make up for the refreshes skipped while calibration ran; calibration takes roughly 20 us and one refresh period is roughly 7.8 us. Last, it writes the saved interval back. A programmable timeout bounds the wait for completion. If the timeout expires, the sequence aborts into the same clean-up path and an error flag is raised. A one-cycle done pulse marks the end of every sequence.

Top module: `gate_train_seq`

## Requirements
- R1: A start accepted while idle captures `rfi_rdata_i` and, in the next cycle, writes zero to the refresh-interval register (`rfi_we_o`=1, `rfi_wdata_o`=0). This is the first interval write of the sequence.
- R2: The cycle after the zero write, the PHY control field is written with 2'b01. Bit 1 is the mode (0 = normal) and bit 0 is the start flag (1 = start calibration). No calibration start write happens while the interval still holds a nonzero value written by this block.
- R3: Calibration counts as complete only when `cal_stat_i` reads 2'b11 in a single cycle. Bit 1 is the high-byte done flag and bit 0 is the low-byte done flag. One flag alone never completes it.
- R4: The cycle after completion is seen, the PHY control field is written with 2'b00 (mode normal, no calibration).
- R5: After the control rewrite, exactly NUM_REF (default 3) refresh requests are issued. Each `ref_req_o` is held until `ref_ack_i` is seen, and the next request rises only after at least one low cycle following that acknowledge.
- R6: The saved interval is written back (`rfi_wdata_o` = captured value) only after the last refresh is acknowledged. The interval register stays at zero from the zero write until then.
- R7: Completion is checked on each wait cycle, counted from 0. If completion is not seen by wait cycle `tmo_limit_i`, the block aborts in the next cycle: it raises `err_o`, writes 2'b00 to the control field, and still issues the refresh burst and restores the interval.
- R8: `done_o` is a single-cycle pulse in the cycle after the restore write. `busy_o` is high from the cycle after an accepted start through the done pulse. `err_o` holds its value until the next accepted start clears it.
- R9: `start_i` is ignored while `busy_o` is high. A sequence makes exactly one calibration-start write, one burst and one done pulse.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `rfi_we_o`, `cal_ctrl_we_o` and `ref_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one training sequence |
| tmo_limit_i | input | TO_W | Last wait cycle on which completion is accepted; hold stable while busy |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence aborted on timeout |
| rfi_rdata_i | input | RFI_W | Current refresh-interval register value |
| rfi_we_o | output | 1 | Refresh-interval register write strobe |
| rfi_wdata_o | output | RFI_W | Refresh-interval register write data |
| cal_ctrl_we_o | output | 1 | PHY calibration control write strobe |
| cal_ctrl_o | output | 2 | PHY control field: bit1 mode (0 normal), bit0 start |
| cal_stat_i | input | 2 | PHY status: bit1 high-byte done, bit0 low-byte done |
| ref_req_o | output | 1 | Refresh command request |
| ref_ack_i | input | 1 | Refresh command completed |

## Verification
Every cycle, the assertions check the local ordering rules. A calibration start write must directly follow a zero write to the interval. A request held without acknowledge must stay high. The restore write can only happen once the burst counter is full. The done pulse lasts a single cycle. Busy never drops before done. Both status flags together must trigger the stop write in the next cycle. Only the bench scenarios can show end-to-end behaviour: the exact refresh count, the restored value matching the captured one, the timeout boundary at limit versus limit+1, staggered or single-lane completion flags, and start pulses ignored mid-sequence.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ZERO,
    ST_CALGO,
    ST_WAIT,
    ST_STOP,
    ST_REFREQ,
    ST_REFGAP,
    ST_RESTORE,
    ST_FIN
  } gt_state_e;

  localparam logic [1:0] CTL_CAL_START = 2'b01;
  localparam logic [1:0] CTL_NO_CAL    = 2'b00;
  localparam logic [1:0] STAT_BOTH     = 2'b11;
endpackage

// File: rtl/gt_wait_timer.sv
module gt_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (run_i) cnt_d = cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == limit_i);

  // the wait never runs past the programmed limit
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/gt_ref_counter.sv
module gt_ref_counter #(
  parameter int NUM_REF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(NUM_REF + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(NUM_REF));

  assert_ref_cnt_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NUM_REF));
endmodule

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import gt_pkg::*;
#(
  parameter int RFI_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       cal_stat_i,
  input  logic             ref_ack_i,
  input  logic [RFI_W-1:0] rfi_rdata_i,
  input  logic             tmo_i,
  input  logic             burst_last_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             rfi_we_o,
  output logic [RFI_W-1:0] rfi_wdata_o,
  output logic             cal_ctrl_we_o,
  output logic [1:0]       cal_ctrl_o,
  output logic             ref_req_o,
  output logic             wait_run_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o
);
  gt_state_e        state_q, state_d;
  logic [RFI_W-1:0] saved_q;
  logic             err_q, err_d;
  logic             save_en;
  logic             cal_both;

  assign cal_both = (cal_stat_i == STAT_BOTH);
  assign save_en  = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) begin state_d = ST_ZERO; err_d = 1'b0; end
      ST_ZERO:    state_d = ST_CALGO;
      ST_CALGO:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (cal_both)   state_d = ST_STOP;
        else if (tmo_i) begin state_d = ST_STOP; err_d = 1'b1; end
      end
      ST_STOP:    state_d = ST_REFREQ;
      ST_REFREQ:  if (ref_ack_i) state_d = ST_REFGAP;
      ST_REFGAP:  state_d = burst_last_i ? ST_RESTORE : ST_REFREQ;
      ST_RESTORE: state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_q <= '0;
    else if (save_en) saved_q <= rfi_rdata_i;
  end

  always_comb begin
    rfi_we_o      = 1'b0;
    rfi_wdata_o   = '0;
    cal_ctrl_we_o = 1'b0;
    cal_ctrl_o    = CTL_NO_CAL;
    case (state_q)
      ST_ZERO:    rfi_we_o = 1'b1;
      ST_CALGO:   begin cal_ctrl_we_o = 1'b1; cal_ctrl_o = CTL_CAL_START; end
      ST_STOP:    cal_ctrl_we_o = 1'b1;
      ST_RESTORE: begin rfi_we_o = 1'b1; rfi_wdata_o = saved_q; end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign err_o      = err_q;
  assign ref_req_o  = (state_q == ST_REFREQ);
  assign wait_run_o = (state_q == ST_WAIT);
  assign cnt_clr_o  = (state_q == ST_STOP);
  assign cnt_inc_o  = (state_q == ST_REFREQ) && ref_ack_i;

  assert_cal_after_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_ctrl_we_o && cal_ctrl_o == CTL_CAL_START) |->
      ($past(rfi_we_o) && $past(rfi_wdata_o) == '0));

  assert_stop_after_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_run_o && cal_stat_i == STAT_BOTH) |=>
      (cal_ctrl_we_o && cal_ctrl_o == CTL_NO_CAL));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);

  assert_restore_after_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESTORE) |-> burst_last_i);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/gate_train_seq.sv
module gate_train_seq #(
  parameter int RFI_W   = 16,
  parameter int TO_W    = 16,
  parameter int NUM_REF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TO_W-1:0]  tmo_limit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [RFI_W-1:0] rfi_rdata_i,
  output logic             rfi_we_o,
  output logic [RFI_W-1:0] rfi_wdata_o,
  output logic             cal_ctrl_we_o,
  output logic [1:0]       cal_ctrl_o,
  input  logic [1:0]       cal_stat_i,
  output logic             ref_req_o,
  input  logic             ref_ack_i
);
  logic wait_run, tmo, cnt_clr, cnt_inc, burst_last;

  gt_ctrl #(.RFI_W(RFI_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .cal_stat_i    (cal_stat_i),
    .ref_ack_i     (ref_ack_i),
    .rfi_rdata_i   (rfi_rdata_i),
    .tmo_i         (tmo),
    .burst_last_i  (burst_last),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .rfi_we_o      (rfi_we_o),
    .rfi_wdata_o   (rfi_wdata_o),
    .cal_ctrl_we_o (cal_ctrl_we_o),
    .cal_ctrl_o    (cal_ctrl_o),
    .ref_req_o     (ref_req_o),
    .wait_run_o    (wait_run),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc)
  );

  gt_wait_timer #(.TO_W(TO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (wait_run),
    .limit_i   (tmo_limit_i),
    .expired_o (tmo)
  );

  gt_ref_counter #(.NUM_REF(NUM_REF)) u_refcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (burst_last)
  );
endmodule

// File: tb/tb_gate_train_seq.sv
module tb_gate_train_seq;
  localparam int RFI_W = 16;
  localparam int TO_W  = 16;
  localparam int NEVER = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [TO_W-1:0] tmo_limit_i = '0;
  logic busy_o, done_o, err_o, rfi_we_o, cal_ctrl_we_o, ref_req_o;
  logic [RFI_W-1:0] rfi_wdata_o;
  logic [RFI_W-1:0] rfi_reg = '0;
  logic [1:0] cal_ctrl_o;
  logic [1:0] cal_stat;
  logic ref_ack = 1'b0;

  always #10 clk = ~clk;

  gate_train_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmo_limit_i(tmo_limit_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rfi_rdata_i(rfi_reg), .rfi_we_o(rfi_we_o), .rfi_wdata_o(rfi_wdata_o),
    .cal_ctrl_we_o(cal_ctrl_we_o), .cal_ctrl_o(cal_ctrl_o), .cal_stat_i(cal_stat),
    .ref_req_o(ref_req_o), .ref_ack_i(ref_ack)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int lo_lat = 0, hi_lat = 0, ref_lat = 1;
  logic cal_run = 1'b0;
  int cal_cyc = 0, ref_wait = 0;
  // event log
  int n_zero, n_go, n_stop, n_ref, n_restore, n_done, n_req_rise;
  int c_zero, c_go, c_stop, c_lastack, c_restore, c_done;
  logic rfi_nonzero_in_cal, go_before_zero, prev_req;

  assign cal_stat[0] = cal_run && (lo_lat < NEVER) && (cal_cyc >= lo_lat);
  assign cal_stat[1] = cal_run && (hi_lat < NEVER) && (cal_cyc >= hi_lat);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rfi_we_o) rfi_reg <= rfi_wdata_o;
    if (cal_ctrl_we_o) begin
      cal_run <= cal_ctrl_o[0];
      cal_cyc <= 0;
    end else if (cal_run) cal_cyc <= cal_cyc + 1;
    if (ref_ack) begin ref_ack <= 1'b0; ref_wait <= 0; end
    else if (ref_req_o) begin
      if (ref_wait + 1 >= ref_lat) ref_ack <= 1'b1;
      ref_wait <= ref_wait + 1;
    end
    prev_req <= ref_req_o;
    if (ref_req_o && !prev_req) n_req_rise <= n_req_rise + 1;
    if (rfi_we_o && rfi_wdata_o == '0 && n_zero == 0) begin n_zero <= n_zero + 1; c_zero <= cyc; end
    if (cal_ctrl_we_o && cal_ctrl_o == 2'b01) begin
      n_go <= n_go + 1; c_go <= cyc;
      if (n_zero == 0) go_before_zero <= 1'b1;
    end
    if (cal_ctrl_we_o && cal_ctrl_o == 2'b00) begin n_stop <= n_stop + 1; c_stop <= cyc; end
    if (ref_req_o && ref_ack) begin
      n_ref <= n_ref + 1; c_lastack <= cyc;
      if (rfi_reg != '0) rfi_nonzero_in_cal <= 1'b1;
    end
    if (rfi_we_o && n_zero != 0) begin n_restore <= n_restore + 1; c_restore <= cyc; end
    if (done_o) begin n_done <= n_done + 1; c_done <= cyc; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_zero = 0; n_go = 0; n_stop = 0; n_ref = 0; n_restore = 0; n_done = 0; n_req_rise = 0;
    c_zero = 0; c_go = 0; c_stop = 0; c_lastack = 0; c_restore = 0; c_done = 0;
    rfi_nonzero_in_cal = 1'b0; go_before_zero = 1'b0;
  endtask

  // one sequence; extra_starts pulses start at chosen cycles while busy
  task automatic run_seq(input int init_rfi, input int lo, input int hi, input int lim,
                         input int rlat, input bit extra_starts);
    int mx, exp_err, wait_cnt;
    @(negedge clk);
    rfi_reg = RFI_W'(init_rfi);
    lo_lat = lo; hi_lat = hi; ref_lat = rlat; tmo_limit_i = TO_W'(lim);
    clear_log();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    check(err_o == 1'b0, "R8 err cleared on start", err_o, 0);
    wait_cnt = 0;
    while (!done_o && wait_cnt < 5000) begin
      if (extra_starts && (wait_cnt == 1 || wait_cnt == 4 || wait_cnt == 12)) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_cnt++;
    end
    check(done_o == 1'b1, "R8 done reached", done_o, 1);
    mx = (lo > hi) ? lo : hi;
    exp_err = (mx > lim) ? 1 : 0;
    check(err_o == exp_err[0], "R7 err flag", err_o, exp_err);
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R8 done one cycle", done_o, 0);
    repeat (5) @(negedge clk);
    check(n_done == 1, "R9 single done", n_done, 1);
    check(err_o == exp_err[0], "R8 err held", err_o, exp_err);
    check(n_zero == 1 && c_go == c_zero + 1, "R1 zero write before go", c_go - c_zero, 1);
    check(n_go == 1 && !go_before_zero, "R2/R9 one cal start", n_go, 1);
    if (exp_err == 0)
      check(c_stop == c_go + mx + 2, "R3/R4 stop timing", c_stop - c_go, mx + 2);
    else
      check(c_stop == c_go + lim + 2, "R7 abort timing", c_stop - c_go, lim + 2);
    check(n_stop == 1, "R4 one stop write", n_stop, 1);
    check(n_ref == 3 && n_req_rise == 3, "R5 three refreshes", n_ref, 3);
    check(!rfi_nonzero_in_cal, "R6 interval zero during burst", rfi_nonzero_in_cal, 0);
    check(n_restore == 1 && c_restore == c_lastack + 2, "R6 restore after last ack",
          c_restore - c_lastack, 2);
    check(rfi_reg == RFI_W'(init_rfi), "R6 interval restored", rfi_reg, init_rfi);
    check(c_done == c_restore + 1, "R8 done after restore", c_done - c_restore, 1);
  endtask

  task automatic test_reset();
    check(!busy_o && !done_o && !err_o && !rfi_we_o && !cal_ctrl_we_o && !ref_req_o,
          "R10 reset outputs", {busy_o, done_o, err_o, rfi_we_o, cal_ctrl_we_o, ref_req_o}, 0);
  endtask

  task automatic test_idle_no_start();
    clear_log();
    repeat (6) @(negedge clk);
    check(n_zero == 0 && n_go == 0 && !busy_o, "R10 idle without start", n_go, 0);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_no_start();
    run_seq(16'h018c, 5, 5, 40, 1, 0);           // R3 both flags together
    run_seq(16'h0200, 3, 9, 40, 3, 0);           // R3 staggered flags
    run_seq(16'h1234, 9, 3, 40, 2, 0);           // R3 other order
    run_seq(16'h0777, 4, NEVER, 12, 1, 0);       // R3 low only -> R7 abort
    run_seq(16'h0abc, NEVER, 4, 12, 1, 0);       // R3 high only -> R7 abort
    run_seq(16'h0055, 8, 8, 8, 1, 0);            // R7 boundary: done on last cycle
    run_seq(16'h0066, 9, 9, 8, 1, 0);            // R7 boundary: one late
    run_seq(16'hffff, 2, 6, 30, 4, 1);           // R9 start while busy
    run_seq(16'h0001, 0, 0, 0, 1, 0);            // immediate completion
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule